// File: doc/BRIEF.md
# Flash Page Write-Protect Range Checker

This block holds the write-protect window settings of a paged flash array and answers, for any page index, whether that page may be changed. Three range registers are kept: a read-only window, a lower read-write window and an upper-bank read-write window. Each window is a pair of page indices. A window with an end index at or above its start index protects every page between the two. A window whose start index is above its end index protects nothing.

A static mode input chooses between one bank and two. With one bank, each window's indices span the whole page space and the upper-bank register has no effect. With two banks, each index is cut to half the page space. The upper-bank register then protects pages in the upper half, and its indices count from the first page of that half. A flash controller presents a page index together with a flag that marks the request as a program or erase. One cycle later it gets a protected flag, and an illegal-write pulse that it uses to reject the operation.

Top module: `wp_guard`

## Requirements
- R1: A range word written to the block carries the start index in bits [PAGE_W-1:0] and the end index in bits [16+PAGE_W-1:16]. Both fields are ANDed with the page mask. The mask is all ones over PAGE_W bits in single-bank mode and all ones over PAGE_W-1 bits in dual-bank mode. All other bits of the word are ignored.
- R2: A window whose masked start equals its masked end protects exactly that one page.
- R3: A window whose masked start is greater than its masked end protects no page.
- R4: A window whose masked start is less than its masked end protects every page from start through end inclusive.
- R5: A page counts as protected when it lies inside the read-only window (select 0) or inside any read-write window (select 1 for lower, select 2 for upper).
- R6: In dual-bank mode (dual_bank_i = 1), an enabled upper-bank window with indices s..e protects absolute pages HALF+s through HALF+e, where HALF is half the page count.
- R7: In dual-bank mode, when the lower read-write window is disabled and the upper-bank window is enabled, the read-write protection is exactly the upper-bank window.
- R8: In single-bank mode (dual_bank_i = 0), the upper-bank register does not affect any query result.
- R9: A query presented with q_valid_i in one cycle yields res_valid_o and res_prot_o in the next cycle. With no query, res_valid_o, res_prot_o and res_illegal_o are all 0 in the following cycle.
- R10: res_illegal_o is 1 for exactly the result cycle of a query that has q_write_i = 1 and targets a protected page. Read queries never raise it.
- R11: After reset, every register holds the disabled encoding (start = all ones over PAGE_W bits, end = 0), so no page is protected.
- R12: A register write takes effect for queries presented in the cycle after the write. A query presented in the same cycle as a write sees the old setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset |
| dual_bank_i | input | 1 | 1 = dual-bank split, 0 = single bank |
| wr_en_i | input | 1 | Range register write strobe |
| wr_sel_i | input | 2 | 0 read-only, 1 lower read-write, 2 upper-bank; 3 ignored |
| wr_data_i | input | 32 | Range word (start low field, end field at bit 16) |
| q_valid_i | input | 1 | Query present |
| q_write_i | input | 1 | Query is a program or erase request |
| q_page_i | input | PAGE_W | Absolute page index queried |
| res_valid_o | output | 1 | Result valid, one cycle after query |
| res_prot_o | output | 1 | Queried page is protected |
| res_illegal_o | output | 1 | Program/erase aimed at a protected page |

## Verification
The bench aims at the window edges: the pages just inside and just outside each bound, a single-page window, and a window whose start sits one above its end. An off-by-one compare or a wrong enable test would then protect one page too many or one too few. Dual-bank cases place the upper window's pages at the half offset and feed in range words with bits set above the mask. A decoder that left out the offset, or applied the mask only in one mode, would then report the wrong half or protect pages far outside the window. Single-bank runs program the upper-bank register to check that it is ignored. A query issued in the same cycle as a write checks that the old setting is used, which catches a write path that bypasses its register.

// File: rtl/wp_guard_pkg.sv
package wp_guard_pkg;

    localparam int unsigned WORD_W     = 32;
    localparam int unsigned END_LSB    = 16;
    localparam int unsigned NUM_RANGES = 3;

    typedef enum logic [1:0] {
        SEL_RO    = 2'd0,
        SEL_RW_LO = 2'd1,
        SEL_RW_HI = 2'd2,
        SEL_NONE  = 2'd3
    } range_sel_e;

endpackage

// File: rtl/wp_range_regs.sv
module wp_range_regs
    import wp_guard_pkg::*;
#(
    parameter int unsigned PAGE_W = 8
) (
    input  logic                               clk_i,
    input  logic                               rst_ni,
    input  logic                               wr_en_i,
    input  logic [1:0]                         wr_sel_i,
    input  logic [WORD_W-1:0]                  wr_data_i,
    output logic [NUM_RANGES-1:0][PAGE_W-1:0]  start_o,
    output logic [NUM_RANGES-1:0][PAGE_W-1:0]  end_o
);

    typedef struct packed {
        logic [NUM_RANGES-1:0][PAGE_W-1:0] first;
        logic [NUM_RANGES-1:0][PAGE_W-1:0] last;
    } bank_t;

    bank_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en_i) begin
            for (int i = 0; i < NUM_RANGES; i++) begin
                if (wr_sel_i == 2'(i)) begin
                    st_d.first[i] = wr_data_i[PAGE_W-1:0];
                    st_d.last[i]  = wr_data_i[END_LSB +: PAGE_W];
                end
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.first <= {NUM_RANGES{ {PAGE_W{1'b1}} }};
            st_q.last  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign start_o = st_q.first;
    assign end_o   = st_q.last;

endmodule

// File: rtl/wp_range_decode.sv
module wp_range_decode #(
    parameter int unsigned PAGE_W = 8,
    parameter bit          UPPER  = 1'b0
) (
    input  logic              dual_i,
    input  logic [PAGE_W-1:0] start_i,
    input  logic [PAGE_W-1:0] end_i,
    input  logic [PAGE_W-1:0] page_i,
    output logic              hit_o
);

    localparam int unsigned HALF_W = PAGE_W - 1;

    logic [PAGE_W-1:0] mask;
    logic [PAGE_W-1:0] lo_idx;
    logic [PAGE_W-1:0] hi_idx;
    logic              enabled;

    always_comb begin
        mask    = dual_i ? {1'b0, {HALF_W{1'b1}}} : {PAGE_W{1'b1}};
        lo_idx  = start_i & mask;
        hi_idx  = end_i & mask;
        enabled = (hi_idx >= lo_idx);
    end

    generate
        if (UPPER) begin : g_upper
            logic [PAGE_W-1:0] rel;
            assign rel   = {1'b0, page_i[HALF_W-1:0]};
            assign hit_o = dual_i & enabled & page_i[PAGE_W-1]
                         & (rel >= lo_idx) & (rel <= hi_idx);
        end else begin : g_lower
            assign hit_o = enabled & (page_i >= lo_idx) & (page_i <= hi_idx);
        end
    endgenerate

endmodule

// File: rtl/wp_query_stage.sv
module wp_query_stage (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic q_valid_i,
    input  logic q_write_i,
    input  logic hit_i,
    output logic valid_o,
    output logic prot_o,
    output logic illegal_o
);

    typedef struct packed {
        logic valid;
        logic prot;
        logic illegal;
    } res_t;

    res_t res_d, res_q;

    always_comb begin
        res_d.valid   = q_valid_i;
        res_d.prot    = q_valid_i & hit_i;
        res_d.illegal = q_valid_i & hit_i & q_write_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) res_q <= '0;
        else         res_q <= res_d;
    end

    assign valid_o   = res_q.valid;
    assign prot_o    = res_q.prot;
    assign illegal_o = res_q.illegal;

endmodule

// File: rtl/wp_guard.sv
module wp_guard
    import wp_guard_pkg::*;
#(
    parameter int unsigned PAGE_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              dual_bank_i,
    input  logic              wr_en_i,
    input  logic [1:0]        wr_sel_i,
    input  logic [31:0]       wr_data_i,
    input  logic              q_valid_i,
    input  logic              q_write_i,
    input  logic [PAGE_W-1:0] q_page_i,
    output logic              res_valid_o,
    output logic              res_prot_o,
    output logic              res_illegal_o
);

    logic [NUM_RANGES-1:0][PAGE_W-1:0] starts;
    logic [NUM_RANGES-1:0][PAGE_W-1:0] ends;
    logic [NUM_RANGES-1:0]             hits;

    wp_range_regs #(.PAGE_W(PAGE_W)) u_regs (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .wr_en_i   (wr_en_i),
        .wr_sel_i  (wr_sel_i),
        .wr_data_i (wr_data_i),
        .start_o   (starts),
        .end_o     (ends)
    );

    generate
        for (genvar g = 0; g < NUM_RANGES; g++) begin : g_win
            wp_range_decode #(
                .PAGE_W (PAGE_W),
                .UPPER  (g == int'(SEL_RW_HI))
            ) u_dec (
                .dual_i  (dual_bank_i),
                .start_i (starts[g]),
                .end_i   (ends[g]),
                .page_i  (q_page_i),
                .hit_o   (hits[g])
            );
        end
    endgenerate

    wp_query_stage u_stage (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .q_valid_i (q_valid_i),
        .q_write_i (q_write_i),
        .hit_i     (|hits),
        .valid_o   (res_valid_o),
        .prot_o    (res_prot_o),
        .illegal_o (res_illegal_o)
    );

endmodule

// File: rtl/wp_guard_chk.sv
module wp_guard_chk (
    input logic clk_i,
    input logic rst_ni,
    input logic q_valid_i,
    input logic q_write_i,
    input logic res_valid_o,
    input logic res_prot_o,
    input logic res_illegal_o
);

    a_r9_result_follows_query: assert property (@(posedge clk_i) disable iff (!rst_ni)
        q_valid_i |=> res_valid_o);

    a_r9_idle_gives_no_result: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !q_valid_i |=> (!res_valid_o && !res_prot_o && !res_illegal_o));

    a_r9_flags_need_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !res_valid_o |-> (!res_prot_o && !res_illegal_o));

    a_r10_illegal_implies_prot: assert property (@(posedge clk_i) disable iff (!rst_ni)
        res_illegal_o |-> res_prot_o);

    a_r10_read_never_illegal: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (q_valid_i && !q_write_i) |=> !res_illegal_o);

endmodule

bind wp_guard wp_guard_chk u_chk (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .q_valid_i     (q_valid_i),
    .q_write_i     (q_write_i),
    .res_valid_o   (res_valid_o),
    .res_prot_o    (res_prot_o),
    .res_illegal_o (res_illegal_o)
);

// File: tb/wp_guard_bench.sv
`timescale 1ns/1ps
module wp_guard_bench;

    localparam int PW    = 8;
    localparam int PAGES = 1 << PW;
    localparam int HALF  = PAGES / 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dual = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [31:0] wr_data = 32'd0;
    logic        q_valid = 1'b0;
    logic        q_write = 1'b0;
    logic [PW-1:0] q_page = '0;
    logic        res_valid, res_prot, res_illegal;

    int checks = 0;
    int fails  = 0;
    int model_w[3];
    bit model_dual = 1'b0;

    wp_guard #(.PAGE_W(PW)) u_wp_guard (
        .clk_i (clk), .rst_ni (rst_n), .dual_bank_i (dual),
        .wr_en_i (wr_en), .wr_sel_i (wr_sel), .wr_data_i (wr_data),
        .q_valid_i (q_valid), .q_write_i (q_write), .q_page_i (q_page),
        .res_valid_o (res_valid), .res_prot_o (res_prot), .res_illegal_o (res_illegal)
    );

    always #2.5 clk = ~clk;

    function automatic int pmask();
        return model_dual ? HALF - 1 : PAGES - 1;
    endfunction

    function automatic bit inside_win(int w, int p, int off);
        int s, e;
        s = w & pmask();
        e = (w >>> 16) & pmask();
        return (e >= s) && (p >= off + s) && (p <= off + e);
    endfunction

    function automatic bit ref_prot(int p);
        bit r;
        r = inside_win(model_w[0], p, 0) || inside_win(model_w[1], p, 0);
        if (model_dual) r = r || inside_win(model_w[2], p, HALF);
        return r;
    endfunction

    function automatic logic [31:0] win(int s, int e);
        return 32'((e << 16) | s);
    endfunction

    task automatic check(string tag, bit ev, bit ep, bit ei);
        checks++;
        if ({res_valid, res_prot, res_illegal} !== {ev, ep, ei}) begin
            fails++;
            $display("FAIL %s: valid/prot/illegal got %b%b%b expected %b%b%b",
                     tag, res_valid, res_prot, res_illegal, ev, ep, ei);
        end
    endtask

    // one clock: drive, compute expectation from pre-edge model, update model, compare
    task automatic cyc(string tag, bit we, int sel, logic [31:0] d, bit qv, bit qw, int page);
        bit ep, ei;
        wr_en = we; wr_sel = 2'(sel); wr_data = d;
        q_valid = qv; q_write = qw; q_page = PW'(page);
        ep = qv && ref_prot(page);
        ei = ep && qw;
        @(posedge clk);
        if (we && sel < 3) model_w[sel] = int'(d);
        @(negedge clk);
        check(tag, qv, ep, ei);
    endtask

    task automatic wr(string tag, int sel, logic [31:0] d);
        cyc(tag, 1'b1, sel, d, 1'b0, 1'b0, 0);
    endtask

    task automatic q(string tag, int page, bit w);
        cyc(tag, 1'b0, 0, 32'd0, 1'b1, w, page);
    endtask

    task automatic set_mode(bit d);
        dual = d;
        model_dual = d;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        fails++;
        $display("FAIL watchdog: run did not complete, got hung expected done");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 3; i++) model_w[i] = PAGES - 1;
        repeat (3) @(negedge clk);
        check("R11 reset outputs", 1'b0, 1'b0, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);

        // R11: nothing protected after reset
        q("R11", 0, 1'b1);
        q("R11", 127, 1'b1);
        q("R11", 255, 1'b1);
        // R9: idle cycle yields no result
        cyc("R9 idle", 1'b0, 0, 32'd0, 1'b0, 1'b0, 0);

        // R2: single-page window
        wr("R2 write", 0, win(2, 2));
        q("R2", 1, 1'b0); q("R2", 2, 1'b0); q("R2", 3, 1'b0);

        // R4: inclusive window edges
        wr("R4 write", 0, win(10, 20));
        q("R4", 9, 1'b0); q("R4", 10, 1'b0); q("R4", 20, 1'b0); q("R4", 21, 1'b0);

        // R3: start one above end is disabled
        wr("R3 write", 1, win(26, 25));
        q("R3", 25, 1'b1); q("R3", 26, 1'b1);

        // R5: union of read-only and read-write windows
        wr("R5 write", 1, win(200, 255));
        q("R5", 15, 1'b1); q("R5", 199, 1'b1); q("R5", 200, 1'b1); q("R5", 255, 1'b1);

        // R1: bits outside the fields ignored
        wr("R1 write", 0, 32'hAB05_CD03);
        q("R1", 2, 1'b0); q("R1", 3, 1'b0); q("R1", 5, 1'b0); q("R1", 6, 1'b0);

        // R8: upper-bank register ignored in single-bank mode
        wr("R8 write", 1, win(255, 0));
        wr("R8 write", 2, win(0, 10));
        q("R8", 128, 1'b1); q("R8", 133, 1'b1); q("R8", 5, 1'b1);

        // R6 / R7: dual-bank split, lower read-write disabled
        set_mode(1'b1);
        wr("R7 write", 0, win(255, 0));
        wr("R6 write", 2, win(2, 4));
        q("R6", 129, 1'b1); q("R6", 130, 1'b1); q("R6", 132, 1'b1); q("R6", 133, 1'b1);
        q("R7", 2, 1'b1); q("R7", 3, 1'b1);

        // R1 in dual mode: mask cuts the top index bit
        wr("R1 dual write", 0, win(8'h85, 8'h90));
        q("R1", 5, 1'b0); q("R1", 16, 1'b0); q("R1", 17, 1'b0); q("R1", 8'h85, 1'b0);

        // R6: both read-write windows active
        wr("R6 write", 1, win(100, 127));
        q("R6", 127, 1'b1); q("R6", 128, 1'b1); q("R6", 131, 1'b1);

        // R10: illegal only for write requests on protected pages
        q("R10", 131, 1'b1); q("R10", 131, 1'b0); q("R10", 60, 1'b1);

        // R12: query in the write cycle sees the old setting
        cyc("R12 same cycle", 1'b1, 0, win(40, 40), 1'b1, 1'b1, 40);
        q("R12 next cycle", 40, 1'b1);
        // select 3 writes nothing
        cyc("R12 sel3", 1'b1, 3, win(0, 127), 1'b1, 1'b1, 50);
        q("R12 sel3", 50, 1'b1);

        // R5 sweeps in both modes
        for (int p = 0; p < PAGES; p++) q("R5 dual sweep", p, p[0]);
        set_mode(1'b0);
        wr("R5 write", 2, win(3, 9));
        for (int p = 0; p < PAGES; p++) q("R5 single sweep", p, p[0]);

        cyc("R9 idle end", 1'b0, 0, 32'd0, 1'b0, 1'b0, 0);
        finish_run();
    end

endmodule